// File: doc/BRIEF.md
# Local Scan Port Park Controller

This block sits behind a scan bridge and manages a small set of downstream JTAG scan ports (three by default). It tracks the upstream TAP from the upstream TMS. For each port it runs an independent selection machine that either splices the port into the active scan chain or parks that port's TAP in a chosen stable state. While a port is parked, the block steers the port's TMS itself until the port's TAP rests in the chosen state.

Park and unpark commands are sampled only at the clock edge where the upstream TAP sits in Update-IR, so the chain length never changes in the middle of a shift. A membership mask chooses which ports an unpark command inserts: none, any single port, any two, or all three. Inserted ports are always chained in ascending port order. An output-enable input lets another test master take over the local TAP pins.

Top module: `lsp_park_ctrl`

## Requirements
- R1: After reset, every port is parked with the Test-Logic-Reset target, `lsp_tms_o` is all ones, `lsp_tdo_o` is all ones and `tdo_o` is 0.
- R2: Park and unpark commands take effect only on a rising edge of `clk_i` where the upstream TAP, tracked from `tms_i` with the standard 16-state controller, is in Update-IR. The new membership is visible right after that edge. At any other edge the commands are ignored.
- R3: On unpark, port k is inserted if bit k-1 of `mode_i` is 1 (bit 0 is port 1) and is parked otherwise. Mode 000 bypasses every port.
- R4: `park_i` takes priority over `unpark_i`. It parks every port and sets its target from `park_state_i`: 00 Test-Logic-Reset, 01 Run-Test/Idle, 10 Pause-DR, 11 Pause-IR.
- R5: A parked port drives its TMS so that its TAP reaches the target within 8 clocks from any state. After that it holds TMS at 1 for Test-Logic-Reset and at 0 for the other three targets.
- R6: The TMS of an inserted port equals `tms_i`.
- R7: Inserted ports are chained in ascending order. The first inserted port receives `tdi_i`. Each later inserted port receives the return data of the previous inserted port. `tdo_o` is the return data of the last inserted port.
- R8: A parked port's `lsp_tdo_o` bit is held at 1, and its `lsp_tdi_i` bit never reaches `tdo_o`.
- R9: With no port inserted, `tdo_o` equals `tdi_i` delayed by one clock.
- R10: Every bit of `lsp_oe_o` equals `oe_i` in the same cycle. When it is low, the pad buffers release the local TAP pins.
- R11: `lsp_tck_o` follows `clk_i` on every port, parked or inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Upstream TCK |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tms_i | input | 1 | Upstream TMS |
| tdi_i | input | 1 | Upstream scan data in |
| tdo_o | output | 1 | Return scan data |
| mode_i | input | N_PORTS | Membership mask for unpark, bit 0 is port 1 |
| park_i | input | 1 | Park command |
| unpark_i | input | 1 | Unpark command |
| park_state_i | input | 2 | Park target encoding |
| oe_i | input | 1 | Local pin output enable |
| lsp_tck_o | output | N_PORTS | Local TCK per port |
| lsp_tms_o | output | N_PORTS | Local TMS per port |
| lsp_tdo_o | output | N_PORTS | Scan data sent into each port |
| lsp_tdi_i | input | N_PORTS | Scan data returned from each port |
| lsp_oe_o | output | N_PORTS | Pad drive enable per port |

## Verification
A command shows its effect one edge after the upstream TAP reaches Update-IR. This is the seventh edge of the walk from Test-Logic-Reset, and the bench checks membership at the falling edge that follows it. The data path and TMS muxing are combinational from state and inputs, so those checks are taken at a falling edge after the inputs have settled. Bypass data appears one rising edge after `tdi_i` changes, and the bench looks for it both before and after that edge. Park convergence is judged by a bench-side TAP model that is fed the port's TMS sampled just before each rising edge and is checked ten edges after the command.

// File: rtl/lspc_pkg.sv
package lspc_pkg;

  typedef enum logic [3:0] {
    TAP_TLR, TAP_RTI, TAP_SEL_DR, TAP_CAP_DR, TAP_SH_DR, TAP_EX1_DR, TAP_PS_DR, TAP_EX2_DR,
    TAP_UPD_DR, TAP_SEL_IR, TAP_CAP_IR, TAP_SH_IR, TAP_EX1_IR, TAP_PS_IR, TAP_EX2_IR, TAP_UPD_IR
  } tap_e;

  typedef enum logic [1:0] {PK_TLR, PK_RTI, PK_PDR, PK_PIR} park_e;

  function automatic tap_e tap_next(tap_e s, logic tms);
    case (s)
      TAP_TLR:    return tms ? TAP_TLR    : TAP_RTI;
      TAP_RTI:    return tms ? TAP_SEL_DR : TAP_RTI;
      TAP_SEL_DR: return tms ? TAP_SEL_IR : TAP_CAP_DR;
      TAP_CAP_DR: return tms ? TAP_EX1_DR : TAP_SH_DR;
      TAP_SH_DR:  return tms ? TAP_EX1_DR : TAP_SH_DR;
      TAP_EX1_DR: return tms ? TAP_UPD_DR : TAP_PS_DR;
      TAP_PS_DR:  return tms ? TAP_EX2_DR : TAP_PS_DR;
      TAP_EX2_DR: return tms ? TAP_UPD_DR : TAP_SH_DR;
      TAP_UPD_DR: return tms ? TAP_SEL_DR : TAP_RTI;
      TAP_SEL_IR: return tms ? TAP_TLR    : TAP_CAP_IR;
      TAP_CAP_IR: return tms ? TAP_EX1_IR : TAP_SH_IR;
      TAP_SH_IR:  return tms ? TAP_EX1_IR : TAP_SH_IR;
      TAP_EX1_IR: return tms ? TAP_UPD_IR : TAP_PS_IR;
      TAP_PS_IR:  return tms ? TAP_EX2_IR : TAP_PS_IR;
      TAP_EX2_IR: return tms ? TAP_UPD_IR : TAP_SH_IR;
      default:    return tms ? TAP_SEL_DR : TAP_RTI;
    endcase
  endfunction

  function automatic tap_e park_to_tap(park_e t);
    case (t)
      PK_TLR:  return TAP_TLR;
      PK_RTI:  return TAP_RTI;
      PK_PDR:  return TAP_PS_DR;
      default: return TAP_PS_IR;
    endcase
  endfunction

  // TMS per current state (bit index = state code) that walks toward each target
  function automatic logic steer_tms(tap_e s, park_e t);
    logic [15:0] v;
    case (t)
      PK_TLR:  v = 16'hFFFF;
      PK_RTI:  v = 16'h7CF8;
      PK_PDR:  v = 16'hFD1A;
      default: v = 16'h8DFE;
    endcase
    return v[s];
  endfunction

endpackage

// File: rtl/lspc_tap_fsm.sv
module lspc_tap_fsm
  import lspc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tms_i,
  output tap_e state_o
);
  tap_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TAP_TLR;
    else         state_q <= tap_next(state_q, tms_i);
  end

  assign state_o = state_q;

  // five TMS highs in a row always reach Test-Logic-Reset (R2 tracking)
  a_r2_tlr_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tms_i && state_q == TAP_SEL_IR) |=> state_q == TAP_TLR);
endmodule

// File: rtl/lspc_port_fsm.sv
module lspc_port_fsm
  import lspc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  upd_i,
  input  logic  park_i,
  input  logic  unpark_i,
  input  logic  sel_i,
  input  park_e tgt_i,
  input  logic  tms_i,
  output logic  inserted_o,
  output logic  tms_o
);
  logic  ins_q;
  park_e tgt_q;
  tap_e  lstate;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ins_q <= 1'b0;
      tgt_q <= PK_TLR;
    end else if (upd_i) begin
      if (park_i) begin
        ins_q <= 1'b0;
        tgt_q <= tgt_i;
      end else if (unpark_i) begin
        ins_q <= sel_i;
      end
    end
  end

  assign tms_o      = ins_q ? tms_i : steer_tms(lstate, tgt_q);
  assign inserted_o = ins_q;

  lspc_tap_fsm u_local (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tms_i  (tms_o),
    .state_o(lstate)
  );

  a_r2_no_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(ins_q));
  a_r3_unpark_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && unpark_i && !park_i) |=> ins_q == $past(sel_i));
  a_r4_park_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && park_i) |=> !ins_q);
  a_r5_park_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ins_q && lstate == park_to_tap(tgt_q) && !(upd_i && (park_i || unpark_i)))
      |=> lstate == $past(lstate));
endmodule

// File: rtl/lspc_chain.sv
module lspc_chain #(
  parameter int N_PORTS = 3
) (
  input  logic [N_PORTS-1:0] ins_i,
  input  logic               tdi_i,
  input  logic               byp_i,
  input  logic [N_PORTS-1:0] ret_i,
  output logic [N_PORTS-1:0] lsp_tdo_o,
  output logic               tdo_o
);
  always_comb begin
    logic cur;
    cur = tdi_i;
    for (int k = 0; k < N_PORTS; k++) begin
      lsp_tdo_o[k] = ins_i[k] ? cur : 1'b1;
      if (ins_i[k]) cur = ret_i[k];
    end
    tdo_o = (|ins_i) ? cur : byp_i;
  end
endmodule

// File: rtl/lsp_park_ctrl.sv
module lsp_park_ctrl
  import lspc_pkg::*;
#(
  parameter int N_PORTS = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tms_i,
  input  logic               tdi_i,
  output logic               tdo_o,
  input  logic [N_PORTS-1:0] mode_i,
  input  logic               park_i,
  input  logic               unpark_i,
  input  logic [1:0]         park_state_i,
  input  logic               oe_i,
  output logic [N_PORTS-1:0] lsp_tck_o,
  output logic [N_PORTS-1:0] lsp_tms_o,
  output logic [N_PORTS-1:0] lsp_tdo_o,
  input  logic [N_PORTS-1:0] lsp_tdi_i,
  output logic [N_PORTS-1:0] lsp_oe_o
);
  tap_e               up_state;
  logic               upd;
  logic               byp_q;
  logic [N_PORTS-1:0] ins;

  lspc_tap_fsm u_up (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tms_i  (tms_i),
    .state_o(up_state)
  );

  assign upd = (up_state == TAP_UPD_IR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) byp_q <= 1'b0;
    else         byp_q <= tdi_i;
  end

  for (genvar k = 0; k < N_PORTS; k++) begin : g_port
    lspc_port_fsm u_port (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .upd_i     (upd),
      .park_i    (park_i),
      .unpark_i  (unpark_i),
      .sel_i     (mode_i[k]),
      .tgt_i     (park_e'(park_state_i)),
      .tms_i     (tms_i),
      .inserted_o(ins[k]),
      .tms_o     (lsp_tms_o[k])
    );
  end

  lspc_chain #(.N_PORTS(N_PORTS)) u_chain (
    .ins_i    (ins),
    .tdi_i    (tdi_i),
    .byp_i    (byp_q),
    .ret_i    (lsp_tdi_i),
    .lsp_tdo_o(lsp_tdo_o),
    .tdo_o    (tdo_o)
  );

  assign lsp_tck_o = {N_PORTS{clk_i}};
  assign lsp_oe_o  = {N_PORTS{oe_i}};

  a_r8_parked_tdo_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins == '0) |-> (lsp_tdo_o == '1));
endmodule

// File: tb/lsp_park_ctrl_bench.sv
module lsp_park_ctrl_bench;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tms = 1'b1, tdi = 1'b0, park = 1'b0, unpark = 1'b0, oe = 1'b1;
  logic [N-1:0] mode = '0, ret = '0;
  logic [1:0] pst = 2'b00;
  logic tdo;
  logic [N-1:0] l_tck, l_tms, l_tdo, l_oe;

  int n_run = 0, n_fail = 0;
  int mstate = 0;   // bench model of port 1 local TAP
  logic tms_smp;

  always #10 clk = ~clk;

  lsp_park_ctrl #(.N_PORTS(N)) u_lsp_park_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tms_i(tms), .tdi_i(tdi), .tdo_o(tdo),
    .mode_i(mode), .park_i(park), .unpark_i(unpark), .park_state_i(pst), .oe_i(oe),
    .lsp_tck_o(l_tck), .lsp_tms_o(l_tms), .lsp_tdo_o(l_tdo), .lsp_tdi_i(ret), .lsp_oe_o(l_oe)
  );

  function automatic int mnext(int s, logic m);
    case (s)
      0: return m ? 0 : 1;    1: return m ? 2 : 1;
      2: return m ? 9 : 3;    3: return m ? 5 : 4;
      4: return m ? 5 : 4;    5: return m ? 8 : 6;
      6: return m ? 7 : 6;    7: return m ? 8 : 4;
      8: return m ? 2 : 1;    9: return m ? 0 : 10;
      10: return m ? 12 : 11; 11: return m ? 12 : 11;
      12: return m ? 15 : 13; 13: return m ? 14 : 13;
      14: return m ? 15 : 11; default: return m ? 2 : 1;
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic tick();
    #5 tms_smp = l_tms[0];
    @(posedge clk);
    if (rst_n) mstate = mnext(mstate, tms_smp);
    @(negedge clk);
  endtask

  task automatic cmd_at_upd(logic p, logic u, logic [1:0] ps);
    tms = 1'b1;
    repeat (5) tick();
    foreach (seq_walk[i]) begin tms = seq_walk[i]; tick(); end
    tms = 1'b0; park = p; unpark = u; pst = ps;
    tick();
    park = 1'b0; unpark = 1'b0;
  endtask

  localparam logic seq_walk [6] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};

  // {mode, tdi, ret, exp_tdo, exp_lsp_tdo}
  typedef struct packed {
    logic [2:0] m; logic d; logic [2:0] r; logic e_tdo; logic [2:0] e_lt;
  } vec_t;
  localparam vec_t VECS [8] = '{
    '{3'b000, 1'b0, 3'b111, 1'b0, 3'b111},
    '{3'b001, 1'b0, 3'b001, 1'b1, 3'b110},
    '{3'b010, 1'b1, 3'b101, 1'b0, 3'b111},
    '{3'b100, 1'b0, 3'b100, 1'b1, 3'b011},
    '{3'b011, 1'b0, 3'b010, 1'b1, 3'b100},
    '{3'b101, 1'b1, 3'b010, 1'b0, 3'b011},
    '{3'b110, 1'b0, 3'b011, 1'b0, 3'b101},
    '{3'b111, 1'b0, 3'b101, 1'b1, 3'b010}
  };

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 tms", 8'(l_tms), 8'h7);
    chk("R1 lsp_tdo", 8'(l_tdo), 8'h7);
    chk("R1 tdo", 8'(tdo), 8'h0);
    rst_n = 1'b1;
    tick();

    // R3 R7 table walk; R2 positive edge timing
    foreach (VECS[i]) begin
      tdi = VECS[i].d; mode = VECS[i].m;
      cmd_at_upd(1'b0, 1'b1, 2'b00);
      ret = VECS[i].r; #1;
      chk("R7 tdo", 8'(tdo), 8'(VECS[i].e_tdo));
      chk("R3 lsp_tdo", 8'(l_tdo), 8'(VECS[i].e_lt));
      tms = 1'b1; #1;
      chk("R6 tms high", 8'(l_tms & VECS[i].m), 8'(VECS[i].m));
      tms = 1'b0; #1;
      chk("R6 tms low", 8'(l_tms & VECS[i].m), 8'h0);
      tick();
    end

    // R4 park into each target, R5 convergence on port 1
    begin
      logic [1:0] tg [4] = '{2'b10, 2'b11, 2'b01, 2'b00};
      int         ex [4] = '{6, 13, 1, 0};
      foreach (tg[i]) begin
        cmd_at_upd(1'b1, 1'b0, tg[i]);
        chk("R4 parked", 8'(l_tdo), 8'h7);
        tms = 1'b0;
        repeat (10) tick();
        chk("R5 state", 8'(mstate), 8'(ex[i]));
        chk("R5 hold tms", 8'(l_tms[0]), 8'(tg[i] == 2'b00));
      end
    end

    // R8 parked return ignored, R9 bypass delay
    ret = 3'b111; tdi = 1'b1; tick();
    chk("R8 tdo", 8'(tdo), 8'h1);
    tdi = 1'b0; #1;
    chk("R9 before edge", 8'(tdo), 8'h1);
    tick();
    chk("R9 after edge", 8'(tdo), 8'h0);

    // R2 unpark ignored away from Update-IR
    mode = 3'b111; unpark = 1'b1; tms = 1'b0;
    repeat (4) tick();
    unpark = 1'b0;
    chk("R2 ignored", 8'(l_tdo), 8'h7);

    // R4 park wins over unpark
    mode = 3'b111;
    cmd_at_upd(1'b1, 1'b1, 2'b01);
    chk("R4 priority", 8'(l_tdo), 8'h7);

    // R10 output enable
    oe = 1'b0; #1;
    chk("R10 oe low", 8'(l_oe), 8'h0);
    oe = 1'b1; #1;
    chk("R10 oe high", 8'(l_oe), 8'h7);

    // R11 local clock
    chk("R11 tck low", 8'(l_tck), 8'h0);
    @(posedge clk); #2;
    chk("R11 tck high", 8'(l_tck), 8'h7);
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule